// File: doc/BRIEF.md
# Paged Data-Memory Command Controller

This block manages a non-volatile data array behind eight byte-wide registers. Software places up to four data bytes and a two-byte address in registers, then writes a command code into a control register. That single write starts the operation. The available operations are a page read, a page program, a page verify, a page erase, a full-array erase, a byte read and a byte program. While the operation runs, a busy flag is raised.

The array holds `PAGES` pages of four bytes each. The default is 1024 pages, or 4 KB. The array is an inferred memory. Erasing sets bytes to FFh. Programming can only clear bits, so a location must be erased before arbitrary data can be stored in it.

A mode flag selects between data-memory operation and a program-memory loading mode. The block only tracks that flag. While the flag is set, every data-memory command is refused.

Top module: `dmem_cmd_ctrl`

## Requirements
- R1: After reset, registers 0 to 6 read 00h, status register 7 reads 00h (bit 0 busy = 0, bit 1 load mode = 0), and `busy` is low.
- R2: Register map: offsets 0 to 3 hold data bytes 0 to 3, offset 4 holds the address low byte, offset 5 the address high byte, offset 6 the command/result register and offset 7 the read-only status register. Code 01h copies bytes 4p to 4p+3 of page p into data bytes 0 to 3, with data byte 0 taking the lowest address.
- R3: Code 02h programs data bytes 0 to 3 into page p. Each stored byte becomes the old value ANDed with the new value, so an erased byte takes the new value exactly.
- R4: Code 04h compares data bytes 0 to 3 with page p. Afterwards register 6 reads 00h on a match and 01h on a mismatch. It keeps that value until the next command is accepted.
- R5: Code 05h sets the four bytes of page p to FFh. Code 06h sets every byte of the array to FFh and holds busy for `PAGES` cycles.
- R6: Code 81h loads the byte at byte address b into data byte 0 and leaves data bytes 1 to 3 unchanged. Code 82h programs data byte 0 into byte b using the same AND rule.
- R7: Code F0h sets load mode and code 0Fh clears it. The mode is visible in status bit 1. While the mode is set, every other code leaves the array untouched and raises no busy.
- R8: An accepted read or verify holds busy for `RD_CYC` cycles, a program for `WR_CYC` cycles and a page erase for `ER_CYC` cycles. Status bit 0 mirrors busy. Every register write made while busy is ignored.
- R9: Any code other than those listed, including the reserved 03h, leaves the array and the data registers unchanged and raises no busy. Register 6 then reads back the written code.
- R10: The page address p is the low log2(`PAGES`) bits of {high, low}. The byte address b is the low log2(`PAGES`)+2 bits. Higher address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| busy | output | 1 | Operation in progress |

## Verification
The bound checker watches, on every cycle, that busy rises only as a result of a write to the command register. It also checks that a page read in data mode always raises busy, that the reserved code never does, that the mode codes set and clear the mode flag, and that the mode cannot change through writes made while busy. The directed scenarios are the only place the array contents are seen. They cover the AND-merge on programming, the erased value, the verify result and how long it persists, address masking, and the busy lengths for each operation.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
    typedef enum logic [3:0] {
        OP_NONE,
        OP_PG_RD,
        OP_PG_WR,
        OP_PG_VFY,
        OP_PG_ERS,
        OP_ALL_ERS,
        OP_BY_RD,
        OP_BY_WR,
        OP_LD_ON,
        OP_LD_OFF
    } op_e;

    localparam int LANES = 4;
    localparam logic [2:0] RA_LO   = 3'd4;
    localparam logic [2:0] RA_HI   = 3'd5;
    localparam logic [2:0] RA_CTL  = 3'd6;
    localparam logic [2:0] RA_STAT = 3'd7;
endpackage

// File: rtl/dmem_cmd_decode.sv
module dmem_cmd_decode
    import dmem_pkg::*;
(
    input  logic [7:0] code,
    input  logic       ld_mode,
    output op_e        op
);
    always_comb begin
        op = OP_NONE;
        case (code)
            8'hF0: op = OP_LD_ON;
            8'h0F: op = OP_LD_OFF;
            8'h01: op = ld_mode ? OP_NONE : OP_PG_RD;
            8'h02: op = ld_mode ? OP_NONE : OP_PG_WR;
            8'h04: op = ld_mode ? OP_NONE : OP_PG_VFY;
            8'h05: op = ld_mode ? OP_NONE : OP_PG_ERS;
            8'h06: op = ld_mode ? OP_NONE : OP_ALL_ERS;
            8'h81: op = ld_mode ? OP_NONE : OP_BY_RD;
            8'h82: op = ld_mode ? OP_NONE : OP_BY_WR;
            default: op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/dmem_array.sv
module dmem_array
    import dmem_pkg::*;
#(
    parameter int PAGES = 1024,
    localparam int PG_W = $clog2(PAGES)
) (
    input  logic                       clk,
    input  logic [LANES-1:0]           wr_en,
    input  logic                       wr_erase,
    input  logic [PG_W-1:0]            wr_page,
    input  logic [LANES-1:0][7:0]      wr_data,
    input  logic [PG_W-1:0]            rd_page,
    output logic [LANES-1:0][7:0]      rd_data
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] mem [PAGES];

        always_ff @(posedge clk) begin
            if (wr_en[g]) begin
                mem[wr_page] <= wr_erase ? 8'hFF : (mem[wr_page] & wr_data[g]);
            end
        end

        assign rd_data[g] = mem[rd_page];
    end
endmodule

// File: rtl/dmem_cmd_ctrl.sv
module dmem_cmd_ctrl
    import dmem_pkg::*;
#(
    parameter int PAGES  = 1024,
    parameter int RD_CYC = 2,
    parameter int WR_CYC = 8,
    parameter int ER_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       busy
);
    localparam int PG_W    = $clog2(PAGES);
    localparam int BA_W    = PG_W + 2;
    localparam int MAX_LAT = (RD_CYC > WR_CYC) ? ((RD_CYC > ER_CYC) ? RD_CYC : ER_CYC)
                                               : ((WR_CYC > ER_CYC) ? WR_CYC : ER_CYC);
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    typedef struct packed {
        logic [LANES-1:0][7:0] data;
        logic [7:0]            lo;
        logic [7:0]            hi;
        logic [7:0]            ctl;
        logic                  ld_mode;
        logic [CNT_W-1:0]      cnt;
        logic                  sweep;
        logic [PG_W-1:0]       swp_pg;
    } state_t;

    state_t q, d;

    logic [15:0]           addr16;
    logic [PG_W-1:0]       page_a;
    logic [BA_W-1:0]       byte_a;
    logic [1:0]            lane;
    logic                  unused_hi_bits;
    logic                  accept;
    op_e                   op;
    logic [PG_W-1:0]       rd_page;
    logic [LANES-1:0][7:0] rd_data;
    logic [LANES-1:0]      wr_en;
    logic                  wr_erase;
    logic [PG_W-1:0]       wr_page;
    logic [LANES-1:0][7:0] wr_data;
    logic                  mode_w;

    assign addr16         = {q.hi, q.lo};
    assign page_a         = addr16[PG_W-1:0];
    assign byte_a         = addr16[BA_W-1:0];
    assign lane           = byte_a[1:0];
    assign unused_hi_bits = ^addr16[15:BA_W];
    assign busy           = (q.cnt != '0) || q.sweep;
    assign accept         = reg_we && !busy;
    assign mode_w         = q.ld_mode;

    dmem_cmd_decode u_dec (
        .code    (reg_wdata),
        .ld_mode (q.ld_mode),
        .op      (op)
    );

    assign rd_page = (op == OP_BY_RD || op == OP_BY_WR) ? byte_a[BA_W-1:2] : page_a;

    dmem_array #(.PAGES(PAGES)) u_arr (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_erase (wr_erase),
        .wr_page  (wr_page),
        .wr_data  (wr_data),
        .rd_page  (rd_page),
        .rd_data  (rd_data)
    );

    always_comb begin
        d        = q;
        wr_en    = '0;
        wr_erase = 1'b0;
        wr_page  = rd_page;
        wr_data  = q.data;

        if (q.cnt != '0) d.cnt = q.cnt - 1'b1;

        if (q.sweep) begin
            wr_en    = '1;
            wr_erase = 1'b1;
            wr_page  = q.swp_pg;
            d.swp_pg = q.swp_pg + 1'b1;
            if (q.swp_pg == PG_W'(PAGES - 1)) d.sweep = 1'b0;
        end

        if (accept) begin
            case (reg_addr)
                RA_LO:   d.lo = reg_wdata;
                RA_HI:   d.hi = reg_wdata;
                RA_STAT: ;
                RA_CTL: begin
                    d.ctl = reg_wdata;
                    case (op)
                        OP_PG_RD: begin
                            d.data = rd_data;
                            d.cnt  = CNT_W'(RD_CYC);
                        end
                        OP_PG_WR: begin
                            wr_en = '1;
                            d.cnt = CNT_W'(WR_CYC);
                        end
                        OP_PG_VFY: begin
                            d.ctl = (rd_data != q.data) ? 8'h01 : 8'h00;
                            d.cnt = CNT_W'(RD_CYC);
                        end
                        OP_PG_ERS: begin
                            wr_en    = '1;
                            wr_erase = 1'b1;
                            d.cnt    = CNT_W'(ER_CYC);
                        end
                        OP_ALL_ERS: begin
                            d.sweep  = 1'b1;
                            d.swp_pg = '0;
                        end
                        OP_BY_RD: begin
                            d.data[0] = rd_data[lane];
                            d.cnt     = CNT_W'(RD_CYC);
                        end
                        OP_BY_WR: begin
                            wr_en   = LANES'(1) << lane;
                            wr_data = {LANES{q.data[0]}};
                            d.cnt   = CNT_W'(WR_CYC);
                        end
                        OP_LD_ON:  d.ld_mode = 1'b1;
                        OP_LD_OFF: d.ld_mode = 1'b0;
                        default: ;
                    endcase
                end
                default: d.data[reg_addr[1:0]] = reg_wdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_addr)
            RA_LO:   reg_rdata = q.lo;
            RA_HI:   reg_rdata = q.hi;
            RA_CTL:  reg_rdata = q.ctl;
            RA_STAT: reg_rdata = {6'b0, q.ld_mode, busy};
            default: reg_rdata = q.data[reg_addr[1:0]];
        endcase
    end
endmodule

// File: rtl/dmem_cmd_ctrl_sva.sv
module dmem_cmd_ctrl_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [2:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       busy,
    input logic       mode
);
    logic ctl_go;
    assign ctl_go = reg_we && !busy && (reg_addr == 3'd6);

    assert_busy_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_we && reg_addr == 3'd6))
        else $error("busy rose without a command write");

    assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we) |=> $stable(mode))
        else $error("mode changed by a write made while busy");

    assert_load_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_go && reg_wdata == 8'hF0) |=> mode)
        else $error("F0h did not set load mode");

    assert_load_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_go && reg_wdata == 8'h0F) |=> !mode)
        else $error("0Fh did not clear load mode");

    assert_read_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_go && reg_wdata == 8'h01 && !mode) |=> busy)
        else $error("page read did not raise busy");

    assert_reserved_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_go && reg_wdata == 8'h03) |=> !busy)
        else $error("reserved code raised busy");
endmodule

bind dmem_cmd_ctrl dmem_cmd_ctrl_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .mode      (mode_w)
);

// File: tb/dmem_cmd_ctrl_bench.sv
module dmem_cmd_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PAGES = 1024;
    localparam int RD_CYC = 2;
    localparam int WR_CYC = 8;
    localparam int ER_CYC = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmem_cmd_ctrl #(.PAGES(PAGES), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .ER_CYC(ER_CYC))
    u_dmem_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic set_addr(input logic [15:0] a);
        wr(3'd4, a[7:0]);
        wr(3'd5, a[15:8]);
    endtask

    task automatic load(input logic [31:0] w);
        for (int i = 0; i < 4; i++) wr(3'(i), w[8*i +: 8]);
    endtask

    task automatic get_data(output logic [31:0] w);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            rd(3'(i), b);
            w[8*i +: 8] = b;
        end
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic cmd(input logic [7:0] c, output int n);
        wr(3'd6, c);
        wait_idle(n);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), v);
            chk("R1", $sformatf("reg %0d after reset", i), {24'b0, v}, 32'h0);
        end
        chk("R1", "busy after reset", {31'b0, busy}, 32'h0);
    endtask

    task automatic t_erase_all;
        int n;
        logic [31:0] w;
        cmd(8'h06, n);
        chk("R5", "full erase busy cycles", n, PAGES);
        set_addr(16'h0000);
        cmd(8'h01, n);
        get_data(w);
        chk("R5", "page 0 after full erase", w, 32'hFFFF_FFFF);
        set_addr(16'(PAGES - 1));
        cmd(8'h01, n);
        get_data(w);
        chk("R5", "last page after full erase", w, 32'hFFFF_FFFF);
    endtask

    task automatic t_page_rw;
        int n;
        logic [31:0] w;
        set_addr(16'h0005);
        load(32'h7856_3412);
        cmd(8'h02, n);
        chk("R8", "page program busy cycles", n, WR_CYC);
        load(32'h0);
        cmd(8'h01, n);
        chk("R8", "page read busy cycles", n, RD_CYC);
        get_data(w);
        chk("R2", "page 5 read back", w, 32'h7856_3412);
        load(32'hF0F0_F0F0);
        cmd(8'h02, n);
        cmd(8'h01, n);
        get_data(w);
        chk("R3", "reprogram ANDs old and new", w, 32'h7050_3010);
        set_addr(16'h0006);
        load(32'h7856_3412);
        cmd(8'h02, n);
    endtask

    task automatic t_byte_ops;
        int n;
        logic [31:0] w;
        load(32'hAABB_CC00);
        set_addr(16'h001A);
        cmd(8'h81, n);
        get_data(w);
        chk("R6", "byte read of 0x1A into data 0 only", w, 32'hAABB_CC56);
        set_addr(16'h001B);
        load(32'h0000_000F);
        cmd(8'h82, n);
        chk("R8", "byte program busy cycles", n, WR_CYC);
        load(32'h0);
        set_addr(16'h0006);
        cmd(8'h01, n);
        get_data(w);
        chk("R6", "byte program 0x1B ANDed, other bytes kept", w, 32'h0856_3412);
    endtask

    task automatic t_verify;
        int n;
        logic [7:0] v;
        set_addr(16'h0006);
        load(32'h0856_3412);
        cmd(8'h04, n);
        rd(3'd6, v);
        chk("R4", "verify match result", {24'b0, v}, 32'h00);
        load(32'h0856_3413);
        cmd(8'h04, n);
        rd(3'd6, v);
        chk("R4", "verify mismatch result", {24'b0, v}, 32'h01);
        wr(3'd0, 8'h99);
        rd(3'd6, v);
        chk("R4", "verify result kept after data write", {24'b0, v}, 32'h01);
    endtask

    task automatic t_mask;
        int n;
        logic [31:0] w;
        load(32'h0);
        set_addr(16'hFC06);
        cmd(8'h01, n);
        get_data(w);
        chk("R10", "page address high bits ignored", w, 32'h0856_3412);
        set_addr(16'hF01A);
        cmd(8'h81, n);
        get_data(w);
        chk("R10", "byte address high bits ignored", w, 32'h0856_3456);
    endtask

    task automatic t_page_erase;
        int n;
        logic [31:0] w;
        set_addr(16'h0006);
        cmd(8'h05, n);
        chk("R8", "page erase busy cycles", n, ER_CYC);
        cmd(8'h01, n);
        get_data(w);
        chk("R5", "page 6 after page erase", w, 32'hFFFF_FFFF);
        set_addr(16'h0005);
        cmd(8'h01, n);
        get_data(w);
        chk("R5", "page 5 untouched by page 6 erase", w, 32'h7050_3010);
    endtask

    task automatic t_load_mode;
        int n;
        logic [7:0] v;
        logic [31:0] w;
        wr(3'd6, 8'hF0);
        rd(3'd7, v);
        chk("R7", "status mode bit after F0h", {24'b0, v}, 32'h02);
        set_addr(16'h0007);
        load(32'h0000_0000);
        wr(3'd6, 8'h02);
        chk("R7", "program refused in load mode (busy)", {31'b0, busy}, 32'h0);
        wr(3'd6, 8'h01);
        get_data(w);
        chk("R7", "read refused in load mode (data kept)", w, 32'h0);
        wr(3'd6, 8'h0F);
        rd(3'd7, v);
        chk("R7", "status mode bit after 0Fh", {24'b0, v}, 32'h00);
        cmd(8'h01, n);
        get_data(w);
        chk("R7", "page 7 unchanged by refused program", w, 32'hFFFF_FFFF);
    endtask

    task automatic t_busy_ignore;
        int n;
        logic [7:0] v;
        logic [31:0] w;
        set_addr(16'h0009);
        load(32'h4433_2211);
        wr(3'd6, 8'h02);
        rd(3'd7, v);
        chk("R8", "status busy bit during program", {24'b0, v}, 32'h01);
        wr(3'd0, 8'hAA);
        wr(3'd6, 8'h06);
        wait_idle(n);
        get_data(w);
        chk("R8", "data write during busy ignored", w, 32'h4433_2211);
        rd(3'd6, v);
        chk("R8", "command during busy ignored", {24'b0, v}, 32'h02);
        set_addr(16'h0005);
        load(32'h0);
        cmd(8'h01, n);
        get_data(w);
        chk("R8", "full erase during busy not run", w, 32'h7050_3010);
    endtask

    task automatic t_unknown;
        logic [7:0] v;
        logic [31:0] w;
        load(32'hDEAD_BEEF);
        wr(3'd6, 8'h55);
        chk("R9", "unknown code raises no busy", {31'b0, busy}, 32'h0);
        wr(3'd6, 8'h03);
        chk("R9", "reserved code raises no busy", {31'b0, busy}, 32'h0);
        get_data(w);
        chk("R9", "data kept after unknown codes", w, 32'hDEAD_BEEF);
        rd(3'd6, v);
        chk("R9", "control reads back written code", {24'b0, v}, 32'h03);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_erase_all;
        t_page_rw;
        t_byte_ops;
        t_verify;
        t_mask;
        t_page_erase;
        t_load_mode;
        t_busy_ignore;
        t_unknown;
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule